// File: doc/BRIEF.md
# Serial Control-Word Loader for a Direct Digital Synthesizer

This block sits on the controller side of a direct digital synthesis chip. It programs the chip over a three-wire serial load link made of a data line, a shift clock and a commit strobe. A request carries a 32-bit frequency tuning word, a 5-bit phase offset, a power-down flag and a 2-bit mode field. The block packs these into one 40-bit control word and shifts the word out one bit per rising edge of the shift clock. It then raises the commit strobe, which makes the new frequency and phase take effect in the synthesizer.

Requests arrive on a valid/ready handshake. A request is taken in the cycle where both `req_valid` and `req_ready` are high. `req_ready` is low for the whole load, including the cycle that carries `done`. A requester that sees `req_ready` low must keep its fields steady if it still wants them sent. Nothing is queued, and a request that is not accepted leaves no trace. The synthesizer runs from a 100 MHz reference, so software computes the tuning word as f_out * 2^32 / 100e6. A tuning word of 42949672 gives roughly 1 MHz.

Top module: `dds_word_loader`

## Requirements
- R1: After reset, `ser_clk`, `ser_commit`, `ser_data`, `done` and `busy` are low and `req_ready` is high.
- R2: A request is accepted only when `req_valid` and `req_ready` are both high. `busy` is high from the cycle after acceptance until the load ends. A request held while busy is not taken, and no extra load results from it.
- R3: The control word has the frequency in bits 0..31, the mode field in bits 32..33, power-down in bit 34 and phase in bits 35..39. It is sent bit 0 first.
- R4: Each load produces exactly 40 rising edges of `ser_clk`. `ser_data` is steady for the whole high phase and for at least one cycle before each rising edge.
- R5: Each low phase of `ser_clk` lasts LO_CYC cycles and each high phase lasts HI_CYC cycles. Both values are at least 1.
- R6: `ser_commit` rises only after the 40th rising edge, once `ser_clk` has been low for LO_CYC cycles. It then stays high for STB_CYC cycles.
- R7: Bits 32..33 of the word sent are always 0, whatever the value on `req_mode`.
- R8: The fields are captured at acceptance. Changing them later does not alter the word being sent.
- R9: `done` is high for exactly one cycle, the cycle right after `ser_commit` falls, and `busy` is still high in that cycle. `req_ready` returns high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A load request is offered |
| req_ready | output | 1 | The loader can take a request this cycle |
| req_freq | input | 32 | Frequency tuning word |
| req_phase | input | 5 | Phase offset |
| req_pdn | input | 1 | Power-down flag |
| req_mode | input | 2 | Mode field; forced to zero in the word sent |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle pulse when a load has finished |
| ser_data | output | 1 | Serial data line to the synthesizer |
| ser_clk | output | 1 | Shift clock; data is taken on its rising edge |
| ser_commit | output | 1 | Commit strobe that applies the loaded word |

## Verification
Two functions can meet in a single cycle: the completion pulse of one load, and a new request that has been held waiting on the handshake. The bench keeps `req_valid` high with fresh fields through the end of a load. It then checks three things: the cycle carrying `done` still shows `req_ready` low, the next cycle shows it high, and the request is taken on exactly that edge. The scoreboard checks that the word for this back-to-back load arrives intact, after exactly 40 edges, with the proper low gap before its commit.

// File: rtl/dds_ldr_pkg.sv
package dds_ldr_pkg;
  localparam int FREQ_W  = 32;
  localparam int PHASE_W = 5;
  localparam int MODE_W  = 2;
  localparam int WORD_W  = FREQ_W + MODE_W + 1 + PHASE_W;

  // Field order, LSB first on the wire: frequency, mode, power-down, phase.
  typedef struct packed {
    logic [PHASE_W-1:0] phase;
    logic               pdn;
    logic [MODE_W-1:0]  mode;
    logic [FREQ_W-1:0]  freq;
  } ctrl_word_t;

  typedef enum logic [2:0] {
    S_IDLE, S_LOW, S_HIGH, S_GAP, S_STROBE, S_DONE
  } seq_state_t;
endpackage

// File: rtl/dds_word_pack.sv
module dds_word_pack
  import dds_ldr_pkg::*;
(
  input  logic [FREQ_W-1:0]  freq_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               pdn_i,
  input  logic [MODE_W-1:0]  mode_i,
  output ctrl_word_t         word_o
);
  // Nonzero mode values reach test modes of the synthesizer; mask them off.
  localparam logic [MODE_W-1:0] MODE_KEEP = '0;

  always_comb begin
    word_o.freq  = freq_i;
    word_o.mode  = mode_i & MODE_KEEP;
    word_o.pdn   = pdn_i;
    word_o.phase = phase_i;
  end
endmodule

// File: rtl/dds_shift_out.sv
module dds_shift_out #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] data_i,
  output logic         bit_o
);
  logic [W-1:0] sreg;

  // Shifting in zeros leaves the line low once the last bit is gone.
  always_ff @(posedge clk) begin
    if (rst)          sreg <= '0;
    else if (load_i)  sreg <= data_i;
    else if (shift_i) sreg <= {1'b0, sreg[W-1:1]};
  end

  assign bit_o = sreg[0];
endmodule

// File: rtl/dds_load_seq.sv
module dds_load_seq
  import dds_ldr_pkg::*;
#(
  parameter int WORD_BITS = 40,
  parameter int LO_CYC    = 2,
  parameter int HI_CYC    = 2,
  parameter int STB_CYC   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic ready_o,
  output logic load_o,
  output logic shift_o,
  output logic wclk_o,
  output logic commit_o,
  output logic done_o,
  output logic busy_o
);
  localparam int CNT_MAX = (LO_CYC > HI_CYC) ? ((LO_CYC > STB_CYC) ? LO_CYC : STB_CYC)
                                             : ((HI_CYC > STB_CYC) ? HI_CYC : STB_CYC);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int BIT_W   = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] LO_END  = CNT_W'(LO_CYC - 1);
  localparam logic [CNT_W-1:0] HI_END  = CNT_W'(HI_CYC - 1);
  localparam logic [CNT_W-1:0] STB_END = CNT_W'(STB_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_BITS - 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitn;

  assign ready_o  = (state == S_IDLE);
  assign load_o   = ready_o && start_i;
  assign shift_o  = (state == S_HIGH) && (cnt == HI_END);
  assign wclk_o   = (state == S_HIGH);
  assign commit_o = (state == S_STROBE);
  assign done_o   = (state == S_DONE);
  assign busy_o   = !ready_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
      bitn  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start_i) begin
          state <= S_LOW;
          cnt   <= '0;
          bitn  <= '0;
        end
        S_LOW: if (cnt == LO_END) begin
          state <= S_HIGH;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        S_HIGH: if (cnt == HI_END) begin
          cnt <= '0;
          if (bitn == LAST_BIT) state <= S_GAP;
          else begin
            state <= S_LOW;
            bitn  <= bitn + 1'b1;
          end
        end else cnt <= cnt + 1'b1;
        S_GAP: if (cnt == LO_END) begin
          state <= S_STROBE;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        S_STROBE: if (cnt == STB_END) begin
          state <= S_DONE;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dds_word_loader.sv
module dds_word_loader
  import dds_ldr_pkg::*;
#(
  parameter int LO_CYC  = 2,
  parameter int HI_CYC  = 2,
  parameter int STB_CYC = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [FREQ_W-1:0]  req_freq,
  input  logic [PHASE_W-1:0] req_phase,
  input  logic               req_pdn,
  input  logic [MODE_W-1:0]  req_mode,
  output logic               busy,
  output logic               done,
  output logic               ser_data,
  output logic               ser_clk,
  output logic               ser_commit
);
  ctrl_word_t word;
  logic       load, shift;

  dds_word_pack u_pack (
    .freq_i(req_freq), .phase_i(req_phase), .pdn_i(req_pdn),
    .mode_i(req_mode), .word_o(word)
  );

  dds_load_seq #(
    .WORD_BITS(WORD_W), .LO_CYC(LO_CYC), .HI_CYC(HI_CYC), .STB_CYC(STB_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .start_i(req_valid), .ready_o(req_ready),
    .load_o(load), .shift_o(shift), .wclk_o(ser_clk), .commit_o(ser_commit),
    .done_o(done), .busy_o(busy)
  );

  dds_shift_out #(.W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .load_i(load), .shift_i(shift),
    .data_i(word), .bit_o(ser_data)
  );
endmodule

// File: rtl/dds_word_loader_chk.sv
module dds_word_loader_chk #(
  parameter int WORD_W  = 40,
  parameter int STB_CYC = 3
) (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic done,
  input logic ser_data,
  input logic ser_clk,
  input logic ser_commit
);
  localparam int RW = $clog2(WORD_W + 2);
  localparam int SW = $clog2(STB_CYC + 2);

  logic          wclk_q;
  logic [RW-1:0] rises;
  logic [SW-1:0] stb_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      wclk_q  <= 1'b0;
      rises   <= '0;
      stb_len <= '0;
    end else begin
      wclk_q <= ser_clk;
      if (req_valid && req_ready)  rises <= '0;
      else if (ser_clk && !wclk_q) rises <= rises + 1'b1;
      if (ser_commit) stb_len <= stb_len + 1'b1;
      else            stb_len <= '0;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!ser_clk && !ser_commit && !ser_data && !done));
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> busy);
  a_r4_data_steady: assert property (@(posedge clk) disable iff (rst)
    ser_clk |-> $stable(ser_data));
  a_r4_forty_edges: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_commit) |-> (rises == RW'(WORD_W)));
  a_r6_commit_after_low: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_commit) |-> (!ser_clk && !$past(ser_clk)));
  a_r6_strobe_min: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_commit) |-> (stb_len >= SW'(STB_CYC)));
  a_r9_done_follows: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(ser_commit) && !ser_commit));
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind dds_word_loader dds_word_loader_chk #(
  .WORD_W(dds_ldr_pkg::WORD_W), .STB_CYC(STB_CYC)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .done(done), .ser_data(ser_data), .ser_clk(ser_clk),
  .ser_commit(ser_commit)
);

// File: tb/sim_dds_word_loader.sv
module sim_dds_word_loader;
  localparam int LO = 2, HI = 3, STB = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_pdn = 1'b0;
  logic [31:0] req_freq = '0;
  logic [4:0]  req_phase = '0;
  logic [1:0]  req_mode = '0;
  logic req_ready, busy, done, ser_data, ser_clk, ser_commit;

  always #2 clk = ~clk;

  dds_word_loader #(.LO_CYC(LO), .HI_CYC(HI), .STB_CYC(STB)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_freq(req_freq), .req_phase(req_phase), .req_pdn(req_pdn),
    .req_mode(req_mode), .busy(busy), .done(done), .ser_data(ser_data),
    .ser_clk(ser_clk), .ser_commit(ser_commit)
  );

  int checks = 0, errors = 0, loads_seen = 0;
  bit wd_hit = 0;
  logic [39:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: rebuild each word from the serial pins and compare on commit.
  logic p_clk = 0, p_commit = 0, p_done = 0, hold_bit = 0;
  int low_run = 0, high_run = 0, stb_run = 0, nbits = 0;
  logic [39:0] got = '0;

  always @(negedge clk) begin
    if (!rst && !wd_hit) begin
      if (ser_clk && !p_clk) begin
        chk(low_run == LO, "R5 low phase length", low_run, LO);
        if (nbits < 40) got[nbits] = ser_data;
        nbits++;
        hold_bit = ser_data;
        high_run = 1;
        low_run = 0;
      end else if (ser_clk) begin
        chk(ser_data == hold_bit, "R4 data steady in high phase", ser_data, hold_bit);
        high_run++;
      end
      if (!ser_clk && p_clk)
        chk(high_run == HI, "R5 high phase length", high_run, HI);
      if (ser_commit && !p_commit) begin
        chk(nbits == 40, "R4 rising edges per load", nbits, 40);
        chk(low_run == LO, "R6 low gap before commit", low_run, LO);
        if (exp_q.size() == 0) chk(0, "R2 unexpected load", got, 0);
        else begin
          logic [39:0] e;
          e = exp_q.pop_front();
          chk(got == e, "R3 R7 R8 word content", got, e);
        end
        loads_seen++;
        stb_run = 0;
        low_run = 0;
      end
      if (ser_commit) stb_run++;
      if (!ser_commit && p_commit) begin
        chk(stb_run == STB, "R6 commit width", stb_run, STB);
        chk(done == 1'b1, "R9 done after commit", done, 1);
        nbits = 0;
      end
      if (done && p_done) chk(0, "R9 done longer than one cycle", 2, 1);
      if (!busy) low_run = 0;
      else if (!ser_clk && !ser_commit && !done) low_run++;
      p_clk = ser_clk; p_commit = ser_commit; p_done = done;
    end
  end

  // Driver: push the expected word, offer it, then scramble the fields.
  task automatic send(input logic [31:0] f, input logic [4:0] p, input logic d, input logic [1:0] m);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_freq = f; req_phase = p; req_pdn = d; req_mode = m; req_valid = 1'b1;
    exp_q.push_back({p, d, 2'b00, f});
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_freq = ~f; req_phase = ~p; req_pdn = ~d; req_mode = ~m;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !wd_hit) begin
      wd_hit = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!ser_clk && !ser_commit && !ser_data, "R1 serial pins low", {ser_clk, ser_commit, ser_data}, 0);
    chk(!done && !busy, "R1 status low", {done, busy}, 0);
    chk(req_ready, "R1 ready after reset", req_ready, 1);

    // about 1 MHz at a 100 MHz reference
    send(32'((64'd1 << 32) * 64'd1000000 / 64'd100000000), 5'h11, 1'b0, 2'b00);
    @(negedge clk);
    chk(busy, "R2 busy after accept", busy, 1);
    wait_idle();

    // all ones with the mode set: mode bits must go out as zero (R7)
    send(32'hFFFF_FFFF, 5'h1F, 1'b1, 2'b11);
    wait_idle();

    // requests offered while busy must be refused (R2)
    send(32'hAAAA_AAAA, 5'h0A, 1'b1, 2'b10);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      req_valid = 1'b1; req_freq = 32'h1234_5678 + i; req_phase = 5'(i);
      chk(!req_ready, "R2 ready low while busy", req_ready, 0);
    end
    req_valid = 1'b0;
    wait_idle();

    // back-to-back: request held through the done pulse
    send(32'h0F0F_3C3C, 5'h05, 1'b0, 2'b01);
    req_freq = 32'h8000_0001; req_phase = 5'h10; req_pdn = 1'b1; req_mode = 2'b11;
    req_valid = 1'b1;
    exp_q.push_back({5'h10, 1'b1, 2'b00, 32'h8000_0001});
    while (!done) @(negedge clk);
    chk(!req_ready && busy, "R9 still busy with done", {req_ready, busy}, 2'b01);
    @(negedge clk);
    chk(req_ready && !done, "R9 ready the cycle after done", {req_ready, done}, 2'b10);
    @(negedge clk);
    chk(busy, "R2 held request taken right after done", busy, 1);
    req_valid = 1'b0;
    req_freq = '0; req_phase = '0; req_pdn = 1'b0;
    wait_idle();

    send(32'h0000_0000, 5'h00, 1'b0, 2'b00);
    wait_idle();
    repeat (5) @(negedge clk);
    chk(loads_seen == 6, "R2 number of loads", loads_seen, 6);
    chk(exp_q.size() == 0, "R2 all expected words seen", exp_q.size(), 0);
    chk(!ser_clk && !ser_commit && !ser_data, "R1 pins low when idle", {ser_clk, ser_commit, ser_data}, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule